// File: doc/BRIEF.md
# Gated Five-Channel Trigger Rate Counter

This block measures trigger rates over a programmable gate. Five counters share a single gate. Four of them count pulses from the individual trigger patches, and the fifth counts pulses from the combined coincidence output. The inputs are already synchronous to the system clock. Each cycle in which an input is high while the gate is open adds one to that channel. A free-running tick enable, nominally 1 MHz, sets the pace of the gate. The gate length comes from an 8-bit prescale `y` as `(y+1)` half-seconds at the default tick scale.

Results are published only for gates that ran to their end without a restart. On publication the five counts are copied to 32-bit output registers with their upper bits zero. Each channel's sticky overflow bit is copied at the same time, and a one-cycle done strobe marks the update. A restart request, issued whenever the surrounding settings change, abandons the running gate, clears the live counters and samples the prescale again.

The control is a three-state machine:
- `ST_LOAD` samples the prescale and clears the timers and counters.
- `ST_GATE` counts triggers and ticks.
- `ST_PUBLISH` is the single cycle in which the results are copied out.

Its transitions are:
- reset to `ST_LOAD`.
- `ST_LOAD` to `ST_GATE` after one cycle.
- `ST_GATE` to `ST_PUBLISH` on the last tick of the gate.
- `ST_PUBLISH` to `ST_GATE`, which starts the next gate at once.
- any state to `ST_LOAD` when `restart` is high.

Top module: `rate_gate_counter`

## Requirements
- R1: While reset is held and after it is released, all five published counts and the overflow vector read zero and `done_o` is low until the first completed gate.
- R2: Input bit mapping on `trig_in`:
  - bits 0 to 3 are patches A to D, driving `cnt_a` to `cnt_d`.
  - bit 4 is the combined trigger, driving `cnt_trig`.

  Every cycle in the `ST_GATE` state with a bit high adds one to that channel. All channels share the same gate.
- R3: A gate spans `(y+1)*HALF_TICKS` cycles with `tick_en` high (default `HALF_TICKS` = 500000, so `(y+1)/2` s at 1 MHz). If `restart` is sampled at edge E and `tick_en` is held high, `done_o` and the new results appear just after edge `E+(y+1)*HALF_TICKS+2`, and not before.
- R4: Cycles with `tick_en` low do not advance the gate. Triggers in those cycles are still counted.
- R5: A live counter stops at `2^CNT_W-1` rather than wrapping. A hit at that value sets the channel's overflow bit, which stays set for the rest of the gate. Each new gate starts with counts and overflow bits cleared.
- R6: `ovf_flags` bit 0 belongs to patch A, bits 1 to 3 to patches B to D, and bit 4 to the combined trigger. The vector is published together with the counts.
- R7: Each published count is 32 bits wide, with the live `CNT_W`-bit value in the low bits and zeros above.
- R8: A `restart` abandons the running gate. No done strobe occurs for it, the published values keep their previous contents, and the live counts restart from zero.
- R9: `prescale` is sampled only in the `ST_LOAD` cycle that follows a reset or restart. Later changes have no effect on the running gate or on the gates that follow.
- R10: `done_o` is high for exactly one cycle, in the cycle in which the outputs take new values. The published outputs do not change in any other cycle.
- R11: A new gate starts right after publication, so consecutive done strobes are one gate plus one cycle apart. Trigger inputs are ignored during the `ST_LOAD` and `ST_PUBLISH` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base enable that advances the gate |
| trig_in | input | 5 | Trigger pulses: patches A-D on bits 0-3, combined trigger on bit 4 |
| prescale | input | 8 | Gate length selector y |
| restart | input | 1 | Settings changed: abandon gate and start over |
| cnt_a | output | 32 | Published count, patch A |
| cnt_b | output | 32 | Published count, patch B |
| cnt_c | output | 32 | Published count, patch C |
| cnt_d | output | 32 | Published count, patch D |
| cnt_trig | output | 32 | Published count, combined trigger |
| ovf_flags | output | 5 | Published overflow bits |
| done_o | output | 1 | One-cycle strobe marking a publication |

## Verification
The bench is built around one fact: with `restart` sampled at edge E, the last gate edge is `E+1+(y+1)*HALF_TICKS*k-(k-1)` for a tick every k cycles. The publish edge follows one cycle later, so results and `done_o` are sampled at the falling edge right after that edge. Each scenario task counts the gate cycles from that formula and drives the pulses of each channel into that window only. It sets every trigger high during the `ST_LOAD` and `ST_PUBLISH` cycles, so that those cycles must show no effect. It requires `done_o` to stay low on every earlier falling edge. Back-to-back gates are checked by starting the next window at the same falling edge that sees the strobe.

// File: rtl/rate_pkg.sv
package rate_pkg;
    localparam int NCH   = 5;
    localparam int OUT_W = 32;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_GATE    = 2'd1,
        ST_PUBLISH = 2'd2
    } gate_state_e;
endpackage

// File: rtl/rate_gate_fsm.sv
module rate_gate_fsm
    import rate_pkg::*;
#(
    parameter int PRE_W      = 8,
    parameter int HALF_TICKS = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             restart,
    input  logic [PRE_W-1:0] prescale,
    output logic             clr_o,
    output logic             cnt_en_o,
    output logic             publish_o
);
    localparam int HALF_W = $clog2(HALF_TICKS + 1);
    localparam logic [HALF_W-1:0] SUB_LAST = HALF_W'(HALF_TICKS - 1);

    gate_state_e       state_q, state_d;
    logic [PRE_W-1:0]  pre_q;
    logic [HALF_W-1:0] sub_q;
    logic [PRE_W-1:0]  half_q;
    logic              sub_wrap;
    logic              last_tick;

    assign sub_wrap  = (sub_q == SUB_LAST);
    assign last_tick = tick_en && sub_wrap && (half_q == pre_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_LOAD:    state_d = ST_GATE;
                ST_GATE:    if (last_tick) state_d = ST_PUBLISH;
                ST_PUBLISH: state_d = ST_GATE;
                default:    state_d = ST_LOAD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        clr_o     = 1'b1;
        cnt_en_o  = 1'b0;
        publish_o = 1'b0;
        unique case (state_q)
            ST_LOAD:    clr_o = 1'b1;
            ST_GATE: begin
                clr_o    = restart;
                cnt_en_o = !restart;
            end
            ST_PUBLISH: publish_o = !restart;
            default:    clr_o = 1'b1;
        endcase
    end

    // two-level gate timer: half-second units times (y+1)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            sub_q  <= '0;
            half_q <= '0;
        end else if (state_q == ST_LOAD) begin
            pre_q  <= prescale;
            sub_q  <= '0;
            half_q <= '0;
        end else if (state_q == ST_GATE && tick_en) begin
            if (sub_wrap) begin
                sub_q  <= '0;
                half_q <= (half_q == pre_q) ? '0 : half_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rate_chan.sv
module rate_chan #(
    parameter int CNT_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (en && hit) begin
            if (&cnt_o) ovf_o <= 1'b1;
            else        cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/rate_gate_counter.sv
module rate_gate_counter
    import rate_pkg::*;
#(
    parameter int CNT_W      = 30,
    parameter int PRE_W      = 8,
    parameter int HALF_TICKS = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [NCH-1:0]   trig_in,
    input  logic [PRE_W-1:0] prescale,
    input  logic             restart,
    output logic [OUT_W-1:0] cnt_a,
    output logic [OUT_W-1:0] cnt_b,
    output logic [OUT_W-1:0] cnt_c,
    output logic [OUT_W-1:0] cnt_d,
    output logic [OUT_W-1:0] cnt_trig,
    output logic [NCH-1:0]   ovf_flags,
    output logic             done_o
);
    localparam int PAD_W = OUT_W - CNT_W;

    logic                 clr, cnt_en, publish;
    logic [CNT_W-1:0]     live_cnt [NCH];
    logic [NCH-1:0]       live_ovf;
    logic [OUT_W-1:0]     pub_cnt  [NCH];
    logic [NCH-1:0]       pub_ovf;
    logic                 done_q;

    rate_gate_fsm #(.PRE_W(PRE_W), .HALF_TICKS(HALF_TICKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .restart   (restart),
        .prescale  (prescale),
        .clr_o     (clr),
        .cnt_en_o  (cnt_en),
        .publish_o (publish)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        rate_chan #(.CNT_W(CNT_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .en    (cnt_en),
            .hit   (trig_in[ch]),
            .cnt_o (live_cnt[ch]),
            .ovf_o (live_ovf[ch])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)       pub_cnt[ch] <= '0;
            else if (publish) pub_cnt[ch] <= {{PAD_W{1'b0}}, live_cnt[ch]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_ovf <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= publish;
            if (publish) pub_ovf <= live_ovf;
        end
    end

    assign cnt_a     = pub_cnt[0];
    assign cnt_b     = pub_cnt[1];
    assign cnt_c     = pub_cnt[2];
    assign cnt_d     = pub_cnt[3];
    assign cnt_trig  = pub_cnt[4];
    assign ovf_flags = pub_ovf;
    assign done_o    = done_q;
endmodule

// File: rtl/rate_gate_counter_chk.sv
module rate_gate_counter_chk #(
    parameter int CNT_W = 30
) (
    input logic        clk,
    input logic        rst_n,
    input logic        restart,
    input logic        done_o,
    input logic [31:0] cnt_a,
    input logic [31:0] cnt_b,
    input logic [31:0] cnt_c,
    input logic [31:0] cnt_d,
    input logic [31:0] cnt_trig,
    input logic [4:0]  ovf_flags
);
    localparam logic [31:0] MAXV = 32'((64'd1 << CNT_W) - 1);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    pub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_c)
                     && $stable(cnt_d) && $stable(cnt_trig) && $stable(ovf_flags)));

    // R5
    ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flags[0] || cnt_a == MAXV) && (!ovf_flags[1] || cnt_b == MAXV)
        && (!ovf_flags[2] || cnt_c == MAXV) && (!ovf_flags[3] || cnt_d == MAXV)
        && (!ovf_flags[4] || cnt_trig == MAXV));

    // R8
    restart_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done_o);
endmodule

bind rate_gate_counter rate_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .done_o    (done_o),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .cnt_c     (cnt_c),
    .cnt_d     (cnt_d),
    .cnt_trig  (cnt_trig),
    .ovf_flags (ovf_flags)
);

// File: tb/rate_gate_counter_tb.sv
module rate_gate_counter_tb;
    localparam int CNT_W = 4;
    localparam int HALF  = 3;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [4:0]  trig_in = '0;
    logic [7:0]  prescale = '0;
    logic        restart = 1'b0;
    logic [31:0] cnt_a, cnt_b, cnt_c, cnt_d, cnt_trig;
    logic [4:0]  ovf_flags;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    int stim [5];
    logic [31:0] exp_cnt [5];
    logic [4:0]  exp_ovf;

    always #4 clk = ~clk;

    rate_gate_counter #(.CNT_W(CNT_W), .PRE_W(8), .HALF_TICKS(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trig_in(trig_in),
        .prescale(prescale), .restart(restart),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_c(cnt_c), .cnt_d(cnt_d),
        .cnt_trig(cnt_trig), .ovf_flags(ovf_flags), .done_o(done_o)
    );

    function automatic logic [31:0] out_cnt(input int c);
        case (c)
            0:       return cnt_a;
            1:       return cnt_b;
            2:       return cnt_c;
            3:       return cnt_d;
            default: return cnt_trig;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_published(input string req);
        for (int c = 0; c < 5; c++) chk(req, $sformatf("count ch%0d", c), out_cnt(c), exp_cnt[c]);
        chk(req, "overflow vector", 32'(ovf_flags), 32'(exp_ovf));
    endtask

    // restart sampled at one edge, LOAD cycle next (all triggers high, must be ignored)
    task automatic restart_gate(input logic [7:0] y);
        @(negedge clk);
        restart = 1'b1; prescale = y; trig_in = '0; tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0; trig_in = 5'h1F;
        @(posedge clk);
        @(negedge clk);
        trig_in = '0;
    endtask

    // starts at the negedge of the first gate cycle; ends at the negedge showing done
    task automatic gate_body(input int y, input int every, input string req);
        int  glen;
        bit  early;
        glen  = (y + 1) * HALF * every - (every - 1);
        early = 1'b0;
        for (int k = 0; k < glen; k++) begin
            if (k > 0 && done_o) early = 1'b1;
            tick_en = ((k % every) == 0);
            for (int c = 0; c < 5; c++) trig_in[c] = (k < stim[c]);
            @(posedge clk);
            @(negedge clk);
        end
        trig_in = 5'h1F;
        tick_en = 1'b1;
        chk("R3", "no done before gate end", 32'(early || done_o), 32'd0);
        @(posedge clk);
        @(negedge clk);
        trig_in = '0;
        chk("R10", "done at publication", 32'(done_o), 32'd1);
        exp_ovf = '0;
        for (int c = 0; c < 5; c++) begin
            exp_cnt[c] = (stim[c] > MAXV) ? 32'(MAXV) : 32'(stim[c]);
            exp_ovf[c] = (stim[c] > MAXV);
        end
        chk_published(req);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 5; c++) chk("R1", "count in reset", out_cnt(c), 32'd0);
        chk("R1", "done in reset", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "ovf after reset", 32'(ovf_flags), 32'd0);
        chk("R1", "done after reset", 32'(done_o), 32'd0);
    endtask

    task automatic t_basic;
        restart_gate(8'd1);
        stim = '{3, 0, 5, 1, 6};
        gate_body(1, 1, "R2");
        restart_gate(8'd0);
        stim = '{1, 2, 3, 0, 2};
        gate_body(0, 1, "R11");
    endtask

    task automatic t_slow_tick;
        restart_gate(8'd2);
        stim = '{1, 4, 0, 9, 17};
        gate_body(2, 2, "R4");
    endtask

    task automatic t_saturate;
        restart_gate(8'd5);
        stim = '{17, 15, 16, 0, 3};
        gate_body(5, 1, "R5");
        chk("R7", "upper bits zero", cnt_a >> CNT_W, 32'd0);
        chk("R6", "ovf bit0 patch A", 32'(ovf_flags[0]), 32'd1);
        stim = '{2, 1, 0, 1, 0};
        gate_body(5, 1, "R5");
    endtask

    task automatic t_abort;
        restart_gate(8'd3);
        for (int k = 0; k < 5; k++) begin
            trig_in = 5'h1F;
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8", "no done mid gate", 32'(done_o), 32'd0);
        restart_gate(8'd1);
        chk_published("R8");
        stim = '{2, 2, 2, 2, 2};
        gate_body(1, 1, "R8");
    endtask

    task automatic t_prescale_hold;
        restart_gate(8'd1);
        prescale = 8'd7;
        stim = '{0, 1, 2, 3, 4};
        gate_body(1, 1, "R9");
        stim = '{4, 3, 2, 1, 0};
        gate_body(1, 1, "R9");
        stim = '{5, 5, 0, 0, 1};
        gate_body(1, 1, "R11");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset;
        t_basic;
        t_slow_tick;
        t_saturate;
        t_abort;
        t_prescale_hold;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule